// File: doc/BRIEF.md
# GPIO Pin Interrupt Generator

This block turns activity on a small port of general-purpose input pins into one interrupt request. Each pin's synchronized level and its direction bit arrive every cycle. Software configures each pin independently through a single-cycle register bus. A pin can watch for a level, for one chosen edge, or for any edge. Every detection sets a sticky raw status bit. A mask selects which raw bits may drive the interrupt line. Software reads the raw view and the masked view, and it acknowledges events by writing ones to a clear location.

The register bus is a plain strobe interface. A cycle with `bus_sel_i` high and `bus_wr_i` high commits a write at the next rising clock edge. A cycle with `bus_sel_i` high and `bus_wr_i` low returns read data combinationally in the same cycle. Word addresses (3 bits):

| Address | Contents |
|---|---|
| 0 | sense select |
| 1 | any-edge select |
| 2 | polarity |
| 3 | mask |
| 4 | raw status, read only |
| 5 | masked status, read only |
| 6 | clear, write only, reads as 0 |
| 7 | unused, reads as 0 |

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every configuration register and the raw status read 0x00 and `irq_o` is low.
- R2: A write to address 0 (sense), 1 (any-edge), 2 (polarity) or 3 (mask) is read back unchanged from the same address from the next cycle on.
- R3: A pin with sense bit 0 and any-edge bit 0 is in single-edge mode. Its raw bit is set when its input level changes and the new level equals its polarity bit: 1 selects rising edges and 0 selects falling edges. The opposite edge leaves the raw bit unchanged.
- R4: A pin with sense bit 0 and any-edge bit 1 sets its raw bit on every change of its input level, rising or falling.
- R5: A pin with sense bit 1 is in level mode. Its raw bit is set in every cycle in which the input level equals its polarity bit, so a clear does not take effect while that level persists. Edges have no effect in level mode.
- R6: Edge detection compares each pin with its value sampled one cycle earlier. It ignores pins whose direction input is 1 (output).
- R7: Address 4 returns the raw status. Address 5 returns raw status AND mask.
- R8: A write to address 6 clears exactly those raw bits whose written bit is 1. All other raw bits are unchanged.
- R9: `irq_o` is high exactly when some raw bit and its mask bit are both 1. A detection becomes visible in the raw status and on `irq_o` in the cycle after the input change is presented.
- R10: When a clear and a new detection hit the same raw bit in the same cycle, the detection wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level_i | input | NPINS | Synchronized level of each pin |
| pin_dir_out_i | input | NPINS | Direction per pin, 1 = output (edge detection off) |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | NPINS | Write data |
| bus_rdata_o | output | NPINS | Read data, same cycle |
| irq_o | output | 1 | Combined masked interrupt request |

## Verification
A software clear of a raw bit and a fresh detection on the same pin can land on the same clock edge. The bench provokes this in two ways. It presents an any-edge transition in the very cycle that carries a clear write for that bit. It also holds a level-mode pin at its active level while clearing it. Either way the raw status read afterwards must still show the bit set. Once the input is quiet, a later clear must drop the bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_SENSE  = 3'd0,
        RA_ANYEDG = 3'd1,
        RA_POL    = 3'd2,
        RA_MASK   = 3'd3,
        RA_RAW    = 3'd4,
        RA_MSKD   = 3'd5,
        RA_CLR    = 3'd6
    } reg_addr_e;

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel_i,
    input  logic                 bus_wr_i,
    input  logic [REG_AW-1:0]    bus_addr_i,
    input  logic [NPINS-1:0]     bus_wdata_i,
    input  logic [NPINS-1:0]     raw_i,
    output logic [NPINS-1:0]     sense_o,
    output logic [NPINS-1:0]     anyedge_o,
    output logic [NPINS-1:0]     pol_o,
    output logic [NPINS-1:0]     mask_o,
    output logic [NPINS-1:0]     clr_o,
    output logic [NPINS-1:0]     rdata_o
);

    typedef struct packed {
        logic [NPINS-1:0] sense;
        logic [NPINS-1:0] anyedge;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] mask;
    } cfg_t;

    cfg_t      cfg_d, cfg_q;
    logic      wr_en, rd_en;
    reg_addr_e addr;

    always_comb begin
        addr    = reg_addr_e'(bus_addr_i);
        wr_en   = bus_sel_i && bus_wr_i;
        rd_en   = bus_sel_i && !bus_wr_i;
        cfg_d   = cfg_q;
        clr_o   = '0;
        rdata_o = '0;
        if (wr_en) begin
            case (addr)
                RA_SENSE:  cfg_d.sense   = bus_wdata_i;
                RA_ANYEDG: cfg_d.anyedge = bus_wdata_i;
                RA_POL:    cfg_d.pol     = bus_wdata_i;
                RA_MASK:   cfg_d.mask    = bus_wdata_i;
                RA_CLR:    clr_o         = bus_wdata_i;
                default:   ;
            endcase
        end
        if (rd_en) begin
            case (addr)
                RA_SENSE:  rdata_o = cfg_q.sense;
                RA_ANYEDG: rdata_o = cfg_q.anyedge;
                RA_POL:    rdata_o = cfg_q.pol;
                RA_MASK:   rdata_o = cfg_q.mask;
                RA_RAW:    rdata_o = raw_i;
                RA_MSKD:   rdata_o = raw_i & cfg_q.mask;
                default:   rdata_o = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign sense_o   = cfg_q.sense;
    assign anyedge_o = cfg_q.anyedge;
    assign pol_o     = cfg_q.pol;
    assign mask_o    = cfg_q.mask;

    // R2
    mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && bus_wr_i && bus_addr_i == RA_MASK) |=> (mask_o == $past(bus_wdata_i)));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int unsigned NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] pin_out_i,
    input  logic [NPINS-1:0] sense_i,
    input  logic [NPINS-1:0] anyedge_i,
    input  logic [NPINS-1:0] pol_i,
    output logic [NPINS-1:0] hit_o
);

    typedef struct packed {
        logic [NPINS-1:0] prev;
    } det_t;

    det_t             det_d, det_q;
    logic [NPINS-1:0] changed;
    logic [NPINS-1:0] at_pol;

    always_comb begin
        det_d      = det_q;
        det_d.prev = pin_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        assign changed[g] = (pin_i[g] ^ det_q.prev[g]) & ~pin_out_i[g];
        assign at_pol[g]  = ~(pin_i[g] ^ pol_i[g]);
        assign hit_o[g]   = sense_i[g] ? at_pol[g]
                                       : (changed[g] & (anyedge_i[g] | at_pol[g]));
    end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int unsigned NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] hit_i,
    input  logic [NPINS-1:0] clr_i,
    input  logic [NPINS-1:0] mask_i,
    output logic [NPINS-1:0] raw_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [NPINS-1:0] raw;
    } stat_t;

    stat_t stat_d, stat_q;

    always_comb begin
        stat_d     = stat_q;
        stat_d.raw = (stat_q.raw & ~clr_i) | hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign raw_o = stat_q.raw;
    assign irq_o = |(stat_q.raw & mask_i);

    // R10
    hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i != '0) |=> ((raw_o & $past(hit_i)) == $past(hit_i)));

    // R8
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~hit_i) != '0) |=> ((raw_o & $past(clr_i & ~hit_i)) == '0));

    // R3
    raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i == '0 && clr_i == '0) |=> $stable(raw_o));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPINS-1:0]     pin_level_i,
    input  logic [NPINS-1:0]     pin_dir_out_i,
    input  logic                 bus_sel_i,
    input  logic                 bus_wr_i,
    input  logic [REG_AW-1:0]    bus_addr_i,
    input  logic [NPINS-1:0]     bus_wdata_i,
    output logic [NPINS-1:0]     bus_rdata_o,
    output logic                 irq_o
);

    logic [NPINS-1:0] sense, anyedge, pol, mask, clr, hit, raw;

    gpio_irq_cfg #(.NPINS(NPINS)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel_i  (bus_sel_i),
        .bus_wr_i   (bus_wr_i),
        .bus_addr_i (bus_addr_i),
        .bus_wdata_i(bus_wdata_i),
        .raw_i      (raw),
        .sense_o    (sense),
        .anyedge_o  (anyedge),
        .pol_o      (pol),
        .mask_o     (mask),
        .clr_o      (clr),
        .rdata_o    (bus_rdata_o)
    );

    gpio_irq_detect #(.NPINS(NPINS)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_level_i),
        .pin_out_i (pin_dir_out_i),
        .sense_i   (sense),
        .anyedge_i (anyedge),
        .pol_i     (pol),
        .hit_o     (hit)
    );

    gpio_irq_status #(.NPINS(NPINS)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (hit),
        .clr_i  (clr),
        .mask_i (mask),
        .raw_o  (raw),
        .irq_o  (irq_o)
    );

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_o);

    // R6
    out_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit & pin_dir_out_i & ~sense) == '0));

endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;

    localparam int unsigned N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pins = '0;
    logic [N-1:0] dirs = '0;
    logic         sel = 1'b0;
    logic         wr = 1'b0;
    logic [2:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         irq;
    logic         probe = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        bit           is_read;
        logic [N-1:0] exp;
        string        tag;
    } item_t;

    item_t sb[$];

    always #2.5 clk = ~clk;

    gpio_irq_ctrl #(.NPINS(N)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_level_i  (pins),
        .pin_dir_out_i(dirs),
        .bus_sel_i    (sel),
        .bus_wr_i     (wr),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .irq_o        (irq)
    );

    // monitor: compares mid-cycle, away from the active edge
    always @(negedge clk) begin
        if (probe) begin
            if (sb.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard empty at probe");
            end else begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (it.is_read) begin
                    if (rdata !== it.exp) begin
                        fails++;
                        $display("FAIL %s read addr=%0d actual=%02h expected=%02h",
                                 it.tag, addr, rdata, it.exp);
                    end
                end else if (irq !== it.exp[0]) begin
                    fails++;
                    $display("FAIL %s irq actual=%0b expected=%0b", it.tag, irq, it.exp[0]);
                end
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [N-1:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        cyc();
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic exp_rd(input logic [2:0] a, input logic [N-1:0] e, input string tag);
        item_t it;
        it.is_read = 1'b1; it.exp = e; it.tag = tag;
        sb.push_back(it);
        sel = 1'b1; wr = 1'b0; addr = a; probe = 1'b1;
        cyc();
        sel = 1'b0; probe = 1'b0;
    endtask

    task automatic exp_irq(input logic e, input string tag);
        item_t it;
        it.is_read = 1'b0; it.exp = {{(N-1){1'b0}}, e}; it.tag = tag;
        sb.push_back(it);
        probe = 1'b1;
        cyc();
        probe = 1'b0;
    endtask

    task automatic set_pins(input logic [N-1:0] v);
        pins = v;
        cyc();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc();

        // R1: reset state
        for (int a = 0; a < 6; a++) exp_rd(3'(a), 8'h00, "R1");
        exp_irq(1'b0, "R1");

        // R2: read back of configuration (polarity first so level mode stays idle)
        wr_reg(3'd2, 8'hF0);
        wr_reg(3'd0, 8'hA0);
        wr_reg(3'd1, 8'h3C);
        wr_reg(3'd3, 8'h0F);
        exp_rd(3'd2, 8'hF0, "R2");
        exp_rd(3'd0, 8'hA0, "R2");
        exp_rd(3'd1, 8'h3C, "R2");
        exp_rd(3'd3, 8'h0F, "R2");
        wr_reg(3'd0, 8'h00);
        wr_reg(3'd1, 8'h00);
        wr_reg(3'd2, 8'h00);
        wr_reg(3'd6, 8'hFF);
        exp_rd(3'd4, 8'h00, "R2");

        // R3: single-edge mode, bit0 rising, bit1 falling
        wr_reg(3'd2, 8'h01);
        wr_reg(3'd3, 8'hFF);
        set_pins(8'h01);
        exp_rd(3'd4, 8'h01, "R3");
        exp_irq(1'b1, "R9");
        wr_reg(3'd6, 8'h01);
        exp_rd(3'd4, 8'h00, "R8");
        exp_irq(1'b0, "R9");
        set_pins(8'h00);
        exp_rd(3'd4, 8'h00, "R3");
        set_pins(8'h02);
        exp_rd(3'd4, 8'h00, "R3");
        set_pins(8'h00);
        exp_rd(3'd4, 8'h02, "R3");
        wr_reg(3'd6, 8'hFF);
        wr_reg(3'd2, 8'h00);

        // R4: any-edge mode on bit2
        wr_reg(3'd1, 8'h04);
        set_pins(8'h04);
        exp_rd(3'd4, 8'h04, "R4");
        wr_reg(3'd6, 8'h04);
        set_pins(8'h00);
        exp_rd(3'd4, 8'h04, "R4");
        wr_reg(3'd6, 8'h04);
        wr_reg(3'd1, 8'h00);

        // R5: level mode on bit3, active high, re-asserts after clear
        wr_reg(3'd2, 8'h08);
        wr_reg(3'd0, 8'h08);
        exp_rd(3'd4, 8'h00, "R5");
        set_pins(8'h08);
        exp_rd(3'd4, 8'h08, "R5");
        wr_reg(3'd6, 8'h08);
        exp_rd(3'd4, 8'h08, "R5");
        set_pins(8'h00);
        wr_reg(3'd6, 8'h08);
        exp_rd(3'd4, 8'h00, "R5");
        wr_reg(3'd0, 8'h00);
        wr_reg(3'd2, 8'h00);

        // R6: output pins produce no edges
        wr_reg(3'd1, 8'h10);
        dirs = 8'h10;
        set_pins(8'h10);
        exp_rd(3'd4, 8'h00, "R6");
        set_pins(8'h00);
        exp_rd(3'd4, 8'h00, "R6");
        dirs = 8'h00;
        set_pins(8'h10);
        exp_rd(3'd4, 8'h10, "R6");
        set_pins(8'h00);
        wr_reg(3'd6, 8'hFF);
        wr_reg(3'd1, 8'h00);

        // R7 / R9 / R8: masked view, irq gating, partial clear
        wr_reg(3'd1, 8'h30);
        set_pins(8'h30);
        wr_reg(3'd3, 8'h10);
        exp_rd(3'd4, 8'h30, "R7");
        exp_rd(3'd5, 8'h10, "R7");
        exp_irq(1'b1, "R9");
        wr_reg(3'd3, 8'h00);
        exp_rd(3'd5, 8'h00, "R7");
        exp_irq(1'b0, "R9");
        wr_reg(3'd3, 8'h20);
        exp_irq(1'b1, "R9");
        wr_reg(3'd6, 8'h10);
        exp_rd(3'd4, 8'h20, "R8");
        exp_irq(1'b1, "R9");
        wr_reg(3'd6, 8'h20);
        exp_irq(1'b0, "R9");
        set_pins(8'h00);
        wr_reg(3'd6, 8'hFF);
        wr_reg(3'd1, 8'h00);
        wr_reg(3'd3, 8'hFF);

        // R10: detection and clear on the same edge
        wr_reg(3'd1, 8'h40);
        pins = 8'h40;
        wr_reg(3'd6, 8'h40);
        exp_rd(3'd4, 8'h40, "R10");
        wr_reg(3'd6, 8'h40);
        exp_rd(3'd4, 8'h00, "R10");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule